// File: doc/BRIEF.md
# Interrupt status and timer registers

This block is a small register file on a simple 64-bit bus. A bus master presents a byte offset, a write enable and write data in one cycle. Writes take effect at the next clock edge. Read data is driven combinationally from the presented offset in the same cycle. The block holds an interrupt enable mask and an interrupt status word. Software can load the status word outright, clear bits of it by mask, or clear bits by writing ones at the status read location.

A free-running counter advances by a fixed step of 1000 on every tick strobe. A compare register sits beside it. A timer interrupt is raised when the dedicated mask bit is enabled and the counter has reached the compare value. A combined interrupt line is high whenever any enabled status bit is set. A constant configuration word and a scratch register complete the map. Any offset not listed below reads as zero and ignores writes.

Top module: `irq_timer_regs`

## Requirements
- R1: After reset, the mask, status, counter, compare and scratch registers all read as zero, and both interrupt outputs are low.
- R2: Offset 0x10000 is the 64-bit interrupt mask, readable and writable.
- R3: A write to offset 0x10020 replaces the whole status word with the write data. A later load does not OR into the earlier value.
- R4: A write to offset 0x10028 clears every status bit that is 1 in the write data. Reads of 0x10028 and of 0x10020 return zero.
- R5: A read of offset 0x10030 returns the status word. A write there clears the status bits that are 1 in the write data.
- R6: `irq_out` is high exactly when (status AND mask) is non-zero, and it reflects a status or mask write from the cycle after that write.
- R7: Offset 0x20000 is a readable and writable 64-bit counter. Each cycle with `tick` high adds 1000 to it, modulo 2^64.
- R8: When a bus write to 0x20000 and `tick` fall in the same cycle, the counter takes the written value.
- R9: Offset 0x30000 is a readable and writable 64-bit compare register.
- R10: `timer_irq_out` is high exactly when mask bit 50 is 1 and the counter is greater than or equal to the compare value, compared as unsigned numbers.
- R11: A read of offset 0x20 returns 0x0000000080010000, and writes to that offset have no effect.
- R12: Offset 0x10018 is a plain 64-bit read/write scratch register.
- R13: Reads of any other offset return zero. Writes to any other offset change no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 20 | Byte offset of the access |
| bus_we | input | 1 | Write enable for the current cycle |
| bus_wdata | input | 64 | Write data |
| bus_rdata | output | 64 | Read data for the presented offset |
| tick | input | 1 | Counter step strobe |
| irq_out | output | 1 | Combined masked status interrupt |
| timer_irq_out | output | 1 | Timer compare interrupt |

## Verification
On every cycle, the assertions check the status update rules: a load leaves exactly the written word, and either clear alias leaves no written-one bit set. They also check the counter step and the write-over-tick priority, that the mask holds without a write, and that neither interrupt can be high while its enable is absent. The bench scenarios are needed for the rest. These are the read decode, with aliases that read as zero and unmapped offsets. They also include counter wraparound, the equal and one-below compare boundaries, and proof that writes to the constant and unmapped offsets leave every register unchanged.

// File: rtl/irq_timer_pkg.sv
package irq_timer_pkg;

   localparam logic [31:0] OFF_CONFIG   = 32'h0000_0020;
   localparam logic [31:0] OFF_MASK     = 32'h0001_0000;
   localparam logic [31:0] OFF_SCRATCH  = 32'h0001_0018;
   localparam logic [31:0] OFF_ST_LOAD  = 32'h0001_0020;
   localparam logic [31:0] OFF_ST_CLEAR = 32'h0001_0028;
   localparam logic [31:0] OFF_ST_VIEW  = 32'h0001_0030;
   localparam logic [31:0] OFF_COUNT    = 32'h0002_0000;
   localparam logic [31:0] OFF_COMPARE  = 32'h0003_0000;

   typedef struct packed {
      logic cfg;
      logic mask;
      logic scratch;
      logic st_load;
      logic st_clear;
      logic st_view;
      logic count;
      logic compare;
   } reg_sel_t;

endpackage

// File: rtl/irq_addr_decode.sv
module irq_addr_decode
   import irq_timer_pkg::*;
#(
   parameter int ADDR_W = 20
) (
   input  logic [ADDR_W-1:0] addr,
   output reg_sel_t          sel
);

   localparam int HI_OFF_BIT = 17;

   if (ADDR_W <= HI_OFF_BIT) begin : g_bad_addr_w
      $error("irq_addr_decode: ADDR_W too narrow for the register map");
   end

   // Every offset is compared over the full address width so that aliases never appear.
   always_comb begin
      sel          = '0;
      sel.cfg      = (addr == ADDR_W'(OFF_CONFIG));
      sel.mask     = (addr == ADDR_W'(OFF_MASK));
      sel.scratch  = (addr == ADDR_W'(OFF_SCRATCH));
      sel.st_load  = (addr == ADDR_W'(OFF_ST_LOAD));
      sel.st_clear = (addr == ADDR_W'(OFF_ST_CLEAR));
      sel.st_view  = (addr == ADDR_W'(OFF_ST_VIEW));
      sel.count    = (addr == ADDR_W'(OFF_COUNT));
      sel.compare  = (addr == ADDR_W'(OFF_COMPARE));
   end

endmodule

// File: rtl/irq_status_unit.sv
module irq_status_unit #(
   parameter int DATA_W = 64
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic              sel_load,
   input  logic              sel_clear,
   input  logic              sel_view,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] status
);

   logic clear_hit;
   logic load_hit;

   assign load_hit  = we && sel_load;
   assign clear_hit = we && (sel_clear || sel_view);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         status <= '0;
      end else if (load_hit) begin
         status <= wdata;
      end else if (clear_hit) begin
         status <= status & ~wdata;
      end
   end

   AST_STATUS_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      load_hit |=> (status == $past(wdata)));  // R3

   AST_STATUS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      clear_hit |=> ((status & $past(wdata)) == '0));  // R4

   AST_STATUS_NO_SET: assert property (@(posedge clk) disable iff (!rst_n)
      clear_hit |=> ((status & ~$past(status)) == '0));  // R5

endmodule

// File: rtl/irq_counter_unit.sv
module irq_counter_unit #(
   parameter int DATA_W    = 64,
   parameter int TICK_STEP = 1000
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic              sel_count,
   input  logic              sel_compare,
   input  logic              tick,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] count,
   output logic [DATA_W-1:0] compare,
   output logic              reached
);

   localparam logic [DATA_W-1:0] STEP_V = DATA_W'(TICK_STEP);

   if (TICK_STEP < 1) begin : g_bad_step
      $error("irq_counter_unit: TICK_STEP must be at least 1");
   end

   logic [DATA_W-1:0] count_next_tick;
   logic              count_wr;

   // A unit step uses a plain incrementer; any other step uses a constant adder.
   if (TICK_STEP == 1) begin : g_step_inc
      assign count_next_tick = count + 1'b1;
   end else begin : g_step_add
      assign count_next_tick = count + STEP_V;
   end

   assign count_wr = we && sel_count;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         count <= '0;
      end else if (count_wr) begin
         count <= wdata;
      end else if (tick) begin
         count <= count_next_tick;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         compare <= '0;
      end else if (we && sel_compare) begin
         compare <= wdata;
      end
   end

   assign reached = (count >= compare);

   AST_TICK_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && !count_wr) |=> (count == $past(count) + STEP_V));  // R7

   AST_WRITE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      count_wr |=> (count == $past(wdata)));  // R8

   AST_COUNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!tick && !count_wr) |=> $stable(count));  // R7

endmodule

// File: rtl/irq_timer_regs.sv
module irq_timer_regs
   import irq_timer_pkg::*;
#(
   parameter int          ADDR_W       = 20,
   parameter int          DATA_W       = 64,
   parameter int          TICK_STEP    = 1000,
   parameter int          TIMER_EN_BIT = 50,
   parameter logic [63:0] CONFIG_WORD  = 64'h0000_0000_8001_0000
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_we,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   input  logic              tick,
   output logic              irq_out,
   output logic              timer_irq_out
);

   if (TIMER_EN_BIT >= DATA_W) begin : g_bad_en_bit
      $error("irq_timer_regs: TIMER_EN_BIT outside the data width");
   end
   if (DATA_W > 64) begin : g_bad_data_w
      $error("irq_timer_regs: DATA_W above 64 is not supported");
   end

   reg_sel_t          sel;
   logic [DATA_W-1:0] mask_q;
   logic [DATA_W-1:0] scratch_q;
   logic [DATA_W-1:0] status;
   logic [DATA_W-1:0] count;
   logic [DATA_W-1:0] compare;
   logic              reached;
   logic [DATA_W-1:0] pend;

   irq_addr_decode #(.ADDR_W(ADDR_W)) u_decode (
      .addr (bus_addr),
      .sel  (sel)
   );

   irq_status_unit #(.DATA_W(DATA_W)) u_status (
      .clk       (clk),
      .rst_n     (rst_n),
      .we        (bus_we),
      .sel_load  (sel.st_load),
      .sel_clear (sel.st_clear),
      .sel_view  (sel.st_view),
      .wdata     (bus_wdata),
      .status    (status)
   );

   irq_counter_unit #(.DATA_W(DATA_W), .TICK_STEP(TICK_STEP)) u_counter (
      .clk         (clk),
      .rst_n       (rst_n),
      .we          (bus_we),
      .sel_count   (sel.count),
      .sel_compare (sel.compare),
      .tick        (tick),
      .wdata       (bus_wdata),
      .count       (count),
      .compare     (compare),
      .reached     (reached)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mask_q    <= '0;
         scratch_q <= '0;
      end else if (bus_we) begin
         if (sel.mask)    mask_q    <= bus_wdata;
         if (sel.scratch) scratch_q <= bus_wdata;
      end
   end

   // Per-bit pending terms, reduced into the combined line.
   for (genvar i = 0; i < DATA_W; i++) begin : g_pend
      assign pend[i] = status[i] & mask_q[i];
   end

   assign irq_out       = |pend;
   assign timer_irq_out = mask_q[TIMER_EN_BIT] & reached;

   always_comb begin
      bus_rdata = '0;
      if (sel.cfg)     bus_rdata = CONFIG_WORD[DATA_W-1:0];
      if (sel.mask)    bus_rdata = mask_q;
      if (sel.scratch) bus_rdata = scratch_q;
      if (sel.st_view) bus_rdata = status;
      if (sel.count)   bus_rdata = count;
      if (sel.compare) bus_rdata = compare;
   end

   AST_MASK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !(bus_we && sel.mask) |=> $stable(mask_q));  // R2

   AST_IRQ_NEEDS_MASK: assert property (@(posedge clk) disable iff (!rst_n)
      (mask_q == '0) |-> !irq_out);  // R6

   AST_IRQ_NEEDS_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
      (status == '0) |-> !irq_out);  // R6

   AST_TIMER_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
      timer_irq_out |-> mask_q[TIMER_EN_BIT]);  // R10

   AST_SEL_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(sel));  // R13

endmodule

// File: tb/irq_timer_regs_tb_top.sv
`timescale 1ns/1ps
module irq_timer_regs_tb_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [19:0] bus_addr = '0;
   logic        bus_we = 1'b0;
   logic [63:0] bus_wdata = '0;
   logic [63:0] bus_rdata;
   logic        tick = 1'b0;
   logic        irq_out;
   logic        timer_irq_out;

   int n_checks = 0;
   int n_errors = 0;

   logic [63:0] m_mask, m_status, m_cnt, m_cmp, m_scr;

   always #2.5 clk = ~clk;

   irq_timer_regs dut_i (
      .clk (clk), .rst_n (rst_n), .bus_addr (bus_addr), .bus_we (bus_we),
      .bus_wdata (bus_wdata), .bus_rdata (bus_rdata), .tick (tick),
      .irq_out (irq_out), .timer_irq_out (timer_irq_out)
   );

   function automatic logic [63:0] exp_read(input logic [19:0] a);
      case (a)
         20'h00020: return 64'h0000_0000_8001_0000;
         20'h10000: return m_mask;
         20'h10018: return m_scr;
         20'h10030: return m_status;
         20'h20000: return m_cnt;
         20'h30000: return m_cmp;
         default:   return 64'h0;
      endcase
   endfunction

   function automatic void model_write(input logic [19:0] a, input logic [63:0] d);
      case (a)
         20'h10000: m_mask = d;
         20'h10018: m_scr = d;
         20'h10020: m_status = d;
         20'h10028: m_status = m_status & ~d;
         20'h10030: m_status = m_status & ~d;
         20'h20000: m_cnt = d;
         20'h30000: m_cmp = d;
         default: ;
      endcase
   endfunction

   function automatic logic exp_irq();
      return (m_status & m_mask) != 64'h0;
   endfunction

   function automatic logic exp_timer();
      return m_mask[50] && (m_cnt >= m_cmp);
   endfunction

   task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // Write with optional simultaneous tick; returns at the negedge after the edge.
   task automatic bus_wr(input logic [19:0] a, input logic [63:0] d, input logic t);
      @(negedge clk);
      bus_addr = a; bus_we = 1'b1; bus_wdata = d; tick = t;
      @(negedge clk);
      bus_we = 1'b0; tick = 1'b0;
      model_write(a, d);
      if (t && a != 20'h20000) m_cnt = m_cnt + 64'd1000;
   endtask

   task automatic do_tick();
      @(negedge clk);
      tick = 1'b1;
      @(negedge clk);
      tick = 1'b0;
      m_cnt = m_cnt + 64'd1000;
   endtask

   task automatic rd_check(input string req, input logic [19:0] a);
      bus_addr = a; bus_we = 1'b0;
      #1;
      check(req, bus_rdata, exp_read(a));
   endtask

   task automatic check_lines(input string req);
      check({req, " irq"}, {63'h0, irq_out}, {63'h0, exp_irq()});
      check({req, " timer"}, {63'h0, timer_irq_out}, {63'h0, exp_timer()});
   endtask

   task automatic check_all_regs(input string req);
      rd_check(req, 20'h10000);
      rd_check(req, 20'h10018);
      rd_check(req, 20'h10030);
      rd_check(req, 20'h20000);
      rd_check(req, 20'h30000);
      rd_check(req, 20'h00020);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_errors++;
      $display("FAIL watchdog actual=%h expected=%h", 64'h1, 64'h0);
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
   end

   localparam logic [19:0] ADDRS [11] = '{20'h00020, 20'h10000, 20'h10018, 20'h10020,
      20'h10028, 20'h10030, 20'h20000, 20'h30000, 20'h10008, 20'h10038, 20'h00000};

   initial begin
      void'($urandom(32'h5eed_2024));
      m_mask = '0; m_status = '0; m_cnt = '0; m_cmp = '0; m_scr = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      check_all_regs("R1");
      check_lines("R1");

      // R11 constant, write ignored
      bus_wr(20'h00020, 64'hFFFF_FFFF_FFFF_FFFF, 1'b0);
      rd_check("R11", 20'h00020);
      check_all_regs("R11");

      // R12 scratch
      bus_wr(20'h10018, 64'hDEAD_BEEF_0123_4567, 1'b0);
      rd_check("R12", 20'h10018);

      // R2 mask
      bus_wr(20'h10000, 64'hA5A5_0000_0000_5A5A, 1'b0);
      rd_check("R2", 20'h10000);
      bus_wr(20'h10000, 64'h0, 1'b0);

      // R3 load replaces
      bus_wr(20'h10020, 64'hF0F0, 1'b0);
      rd_check("R3", 20'h10030);
      bus_wr(20'h10020, 64'h000F, 1'b0);
      rd_check("R3", 20'h10030);

      // R4 clear by mask, aliases read zero
      bus_wr(20'h10028, 64'h3, 1'b0);
      rd_check("R4", 20'h10030);
      rd_check("R4", 20'h10028);
      rd_check("R4", 20'h10020);

      // R5 write-one-to-clear on view offset
      bus_wr(20'h10030, 64'h4, 1'b0);
      rd_check("R5", 20'h10030);

      // R6 combined line
      check_lines("R6");
      bus_wr(20'h10000, 64'h8, 1'b0);
      check_lines("R6");
      check("R6 high", {63'h0, irq_out}, 64'h1);
      bus_wr(20'h10030, 64'h8, 1'b0);
      check("R6 low", {63'h0, irq_out}, 64'h0);

      // R7 step and wrap
      bus_wr(20'h20000, 64'd5, 1'b0);
      do_tick();
      rd_check("R7", 20'h20000);
      check("R7 value", bus_rdata, 64'd1005);
      bus_wr(20'h20000, 64'hFFFF_FFFF_FFFF_FE0C, 1'b0);
      do_tick();
      rd_check("R7 wrap", 20'h20000);
      check("R7 wrap value", bus_rdata, 64'd500);

      // R8 write beats tick
      bus_wr(20'h20000, 64'd77, 1'b1);
      rd_check("R8", 20'h20000);
      check("R8 value", bus_rdata, 64'd77);

      // R9, R10 compare and timer line
      bus_wr(20'h30000, 64'd2000, 1'b0);
      rd_check("R9", 20'h30000);
      bus_wr(20'h10000, 64'h1 << 50, 1'b0);
      bus_wr(20'h20000, 64'd1999, 1'b0);
      check("R10 below", {63'h0, timer_irq_out}, 64'h0);
      bus_wr(20'h20000, 64'd2000, 1'b0);
      check("R10 equal", {63'h0, timer_irq_out}, 64'h1);
      do_tick();
      check("R10 above", {63'h0, timer_irq_out}, 64'h1);
      bus_wr(20'h30000, 64'h8000_0000_0000_0000, 1'b0);
      check("R10 unsigned", {63'h0, timer_irq_out}, 64'h0);
      bus_wr(20'h30000, 64'd0, 1'b0);
      bus_wr(20'h10000, 64'h0, 1'b0);
      check("R10 disabled", {63'h0, timer_irq_out}, 64'h0);

      // R13 unmapped
      bus_wr(20'h10008, 64'hFFFF_FFFF_FFFF_FFFF, 1'b0);
      bus_wr(20'h00000, 64'h1234, 1'b0);
      check_all_regs("R13");
      rd_check("R13", 20'h10008);
      rd_check("R13", 20'h10038);
      check_lines("R13");

      // Constrained random mix
      for (int it = 0; it < 600; it++) begin
         int op = $urandom_range(0, 9);
         logic [19:0] a = ADDRS[$urandom_range(0, 10)];
         logic [63:0] d = {$urandom, $urandom};
         if ($urandom_range(0, 3) == 0) d = d & 64'h0004_0000_0000_00FF;
         if (op < 5) bus_wr(a, d, ($urandom_range(0, 3) == 0));
         else if (op < 7) do_tick();
         else @(negedge clk);
         rd_check("R13 random", a);
         check_lines("R6 R10 random");
      end

      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
   end

endmodule